// File: doc/BRIEF.md
# CPU-Cycle Prescaled Interrupt Timer

This block produces a periodic interrupt request for the CPU without needing any video timing. A fixed prescaler divides the CPU cycle stream by 114, which is roughly one scanline. Each prescaler period steps an 8-bit up-counter. The counter starts from a reload value that software writes as two 4-bit halves. When the counter passes its top value it takes the reload value again and raises a level-sensitive request.

Software loads the two reload halves and then writes a control word. Bit 1 of that word starts the timer. Bit 0 marks the timer as free-running. Any write to the control word acknowledges a pending request. The timer needs no rearming to keep counting: after a wrap it carries on from the reload value. The request stays high until the next control write.

Top module: `irqt_top`

## Requirements
- R1: Synchronous reset drives `irq_o` low and clears the reload value, counter, prescaler and control bits. With no writes after reset, `irq_o` stays low. If the timer is then started with no reload writes, the first interrupt comes after 256 × 114 counted cycles.
- R2: A write (`cpu_wr` high) to address 0xF000 loads reload bits [3:0] from `cpu_data[3:0]`. The upper data bits are ignored.
- R3: A write to address 0xF004 loads reload bits [7:4] from `cpu_data[3:0]`. The upper data bits are ignored.
- R4: A write to address 0xF008 stores `cpu_data[1]` as the run bit and `cpu_data[0]` as the free-run bit. When `cpu_data[1]` is 1, the same write copies the reload value into the counter and zeroes the prescaler. While the run bit is 0, the counter and prescaler hold.
- R5: Every write to 0xF008 drives `irq_o` low on the following cycle, whatever the data.
- R6: While running, the prescaler advances only on cycles with `cpu_cycle` high. Every 114th such cycle produces one counter step. Cycles with `cpu_cycle` low are not counted.
- R7: On a counter step, a count of 0xFF reloads the counter from the reload value and sets `irq_o` on that clock edge. Any other count increments by one. With reload value L, the first request follows (256 − L) × 114 counted cycles after a starting write.
- R8: `irq_o` stays high until a control write, however many further steps or wraps occur. Counting continues after a wrap, whatever the free-run bit.
- R9: Writes to any address other than the three above, and cycles with `cpu_wr` low, change no state.
- R10: A control write in the same cycle as a pending counter step takes priority: the step is dropped and the control write's load and acknowledge take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one clock per write |
| cpu_cycle | input | 1 | High for one clock per CPU cycle |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The timer is run with three reload values: 0x00, which is reached straight from reset, 0xFE and 0xFF. The first interrupt is sampled one cycle before and at its expected edge, which pins down both the nibble placement and the divide ratio. A run with `cpu_cycle` toggling on every clock separates prescaling by CPU cycle from prescaling by clock. Further cases cover a control write that lands on the exact step cycle, writes to nearby wrong addresses while a request is pending, and a stop with acknowledge. Together these separate acknowledge, hold and priority faults. A behavioural model compares `irq_o` on every clock.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int NIB_W = 4;
    localparam int CNT_W = 2 * NIB_W;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [NIB_W-1:0] nibble_t;

    localparam count_t CNT_TOP = '1;

    typedef enum logic [1:0] {
        SEL_NONE     = 2'd0,
        SEL_RELOAD_L = 2'd1,
        SEL_RELOAD_H = 2'd2,
        SEL_CTRL     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic rearm;
    } ctrl_t;

    typedef struct packed {
        reg_sel_e sel;
        nibble_t  nib;
        ctrl_t    ctrl;
    } wr_cmd_t;

    function automatic ctrl_t ctrl_decode(input logic [1:0] bits);
        ctrl_t c;
        c.run   = bits[1];
        c.rearm = bits[0];
        return c;
    endfunction

    function automatic count_t reload_merge(input count_t cur, input nibble_t nib, input logic upper);
        count_t r;
        r = cur;
        if (upper) r[CNT_W-1:NIB_W] = nib;
        else       r[NIB_W-1:0]     = nib;
        return r;
    endfunction

endpackage

// File: rtl/irqt_decode.sv
module irqt_decode
    import irqt_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int unsigned ADDR_RLO  = 32'hF000,
    parameter int unsigned ADDR_RHI  = 32'hF004,
    parameter int unsigned ADDR_CTRL = 32'hF008
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wr_cmd_t           cmd
);

    logic unused_data_hi;
    assign unused_data_hi = ^data[DATA_W-1:NIB_W];

    always_comb begin
        cmd.sel  = SEL_NONE;
        cmd.nib  = data[NIB_W-1:0];
        cmd.ctrl = ctrl_decode(data[1:0]);
        if (wr) begin
            if (addr == ADDR_W'(ADDR_RLO))       cmd.sel = SEL_RELOAD_L;
            else if (addr == ADDR_W'(ADDR_RHI))  cmd.sel = SEL_RELOAD_H;
            else if (addr == ADDR_W'(ADDR_CTRL)) cmd.sel = SEL_CTRL;
        end
    end

endmodule

// File: rtl/irqt_regs.sv
module irqt_regs
    import irqt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    input  logic    wrap,
    output count_t  reload,
    output ctrl_t   ctrl,
    output logic    ctrl_wr,
    output logic    arm
);

    assign ctrl_wr = (cmd.sel == SEL_CTRL);
    assign arm     = ctrl_wr && cmd.ctrl.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
        end else if (cmd.sel == SEL_RELOAD_L) begin
            reload <= reload_merge(reload, cmd.nib, 1'b0);
        end else if (cmd.sel == SEL_RELOAD_H) begin
            reload <= reload_merge(reload, cmd.nib, 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= cmd.ctrl;
        end else if (wrap) begin
            ctrl.run <= ctrl.run | ctrl.rearm;
        end
    end

endmodule

// File: rtl/irqt_prescaler.sv
module irqt_prescaler #(
    parameter int PRESCALE = 114,
    parameter int PW       = $clog2(PRESCALE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          cycle_en,
    input  logic          ctrl_wr,
    input  logic          arm,
    output logic [PW-1:0] presc,
    output logic          tick
);

    localparam logic [PW:0] LIMIT = (PW+1)'(PRESCALE);

    logic          advance;
    logic [PW:0]   sum;
    logic [PW:0]   nxt;

    assign advance = run && cycle_en && !ctrl_wr;
    assign sum     = {1'b0, presc} + {{PW{1'b0}}, 1'b1};
    assign tick    = advance && (sum >= LIMIT);
    assign nxt     = (sum >= LIMIT) ? (sum - LIMIT) : sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc <= '0;
        end else if (arm) begin
            presc <= '0;
        end else if (advance) begin
            presc <= nxt[PW-1:0];
        end
    end

endmodule

// File: rtl/irqt_counter.sv
module irqt_counter
    import irqt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   arm,
    input  logic   ctrl_wr,
    input  count_t reload,
    output count_t count,
    output logic   wrap,
    output logic   irq
);

    assign wrap = tick && (count == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (arm) begin
            count <= reload;
        end else if (tick) begin
            count <= wrap ? reload : count + count_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (ctrl_wr) begin
            irq <= 1'b0;
        end else if (wrap) begin
            irq <= 1'b1;
        end
    end

endmodule

// File: rtl/irqt_top.sv
module irqt_top
    import irqt_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          PRESCALE  = 114,
    parameter int unsigned ADDR_RLO  = 32'hF000,
    parameter int unsigned ADDR_RHI  = 32'hF004,
    parameter int unsigned ADDR_CTRL = 32'hF008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              cpu_cycle,
    output logic              irq_o
);

    localparam int PRESC_W = $clog2(PRESCALE);

    wr_cmd_t            cmd;
    count_t             reload;
    count_t             count;
    ctrl_t              ctrl;
    logic               ctrl_wr;
    logic               arm;
    logic               tick;
    logic               wrap;
    logic [PRESC_W-1:0] presc;

    irqt_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ADDR_RLO (ADDR_RLO),
        .ADDR_RHI (ADDR_RHI),
        .ADDR_CTRL(ADDR_CTRL)
    ) u_decode (
        .wr  (cpu_wr),
        .addr(cpu_addr),
        .data(cpu_data),
        .cmd (cmd)
    );

    irqt_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wrap   (wrap),
        .reload (reload),
        .ctrl   (ctrl),
        .ctrl_wr(ctrl_wr),
        .arm    (arm)
    );

    irqt_prescaler #(
        .PRESCALE(PRESCALE),
        .PW      (PRESC_W)
    ) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .cycle_en(cpu_cycle),
        .ctrl_wr (ctrl_wr),
        .arm     (arm),
        .presc   (presc),
        .tick    (tick)
    );

    irqt_counter u_count (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .arm    (arm),
        .ctrl_wr(ctrl_wr),
        .reload (reload),
        .count  (count),
        .wrap   (wrap),
        .irq    (irq_o)
    );

endmodule

// File: rtl/irqt_checker.sv
module irqt_checker
    import irqt_pkg::*;
#(
    parameter int PRESCALE = 114,
    parameter int PW       = $clog2(PRESCALE)
) (
    input logic          clk,
    input logic          rst,
    input logic          ctrl_wr,
    input logic          arm,
    input logic          tick,
    input logic          wrap,
    input logic          run,
    input count_t        count,
    input count_t        reload,
    input logic [PW-1:0] presc,
    input logic          irq
);

    AST_RESET_IRQ_LOW: assert property (@(posedge clk) rst |=> !irq); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (count == '0 && presc == '0 && !run)); // R1
    AST_ARM_LOAD: assert property (@(posedge clk) disable iff (rst) arm |=> (count == $past(reload) && presc == '0)); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst) ctrl_wr |=> !irq); // R5
    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (rst) ({1'b0, presc} < (PW+1)'(PRESCALE))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!run && !ctrl_wr) |=> ($stable(count) && $stable(presc))); // R6
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst) (tick && count != CNT_TOP) |=> count == count_t'($past(count) + count_t'(1))); // R7
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst) wrap |=> (irq && count == $past(reload))); // R7
    AST_IRQ_ORIGIN: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> $past(wrap)); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst) (irq && !ctrl_wr) |=> irq); // R8
    AST_KEEP_RUN: assert property (@(posedge clk) disable iff (rst) wrap |=> run); // R8

endmodule

bind irqt_top irqt_checker #(
    .PRESCALE(PRESCALE),
    .PW      (PRESC_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctrl_wr(ctrl_wr),
    .arm    (arm),
    .tick   (tick),
    .wrap   (wrap),
    .run    (ctrl.run),
    .count  (count),
    .reload (reload),
    .presc  (presc),
    .irq    (irq_o)
);

// File: tb/tb_irqt_top.sv
`timescale 1ns/1ps
module tb_irqt_top;

    localparam int HALF = 10;
    localparam int LIMIT_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_cycle = 1'b0;
    logic        irq_o;

    int total = 0;
    int fails = 0;
    bit started = 0;

    int m_reload, m_cnt, m_presc;
    bit m_run, m_rearm, m_irq;

    always #HALF clk = ~clk;

    irqt_top dut (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .cpu_cycle(cpu_cycle),
        .irq_o    (irq_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference of the timer
    always @(posedge clk) begin
        int old_reload;
        if (rst) begin
            m_reload = 0; m_cnt = 0; m_presc = 0;
            m_run = 0; m_rearm = 0; m_irq = 0;
        end else begin
            old_reload = m_reload;
            if (cpu_wr && cpu_addr == 16'hF008) begin
                m_run   = cpu_data[1];
                m_rearm = cpu_data[0];
                m_irq   = 0;
                if (cpu_data[1]) begin
                    m_cnt   = old_reload;
                    m_presc = 0;
                end
            end else if (m_run && cpu_cycle) begin
                m_presc = m_presc + 1;
                if (m_presc >= 114) begin
                    m_presc = m_presc - 114;
                    if (m_cnt == 255) begin
                        m_cnt = old_reload;
                        m_irq = 1;
                        m_run = m_run | m_rearm;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
            end
            if (cpu_wr && cpu_addr == 16'hF000) m_reload = (m_reload & 8'hF0) | int'(cpu_data[3:0]);
            if (cpu_wr && cpu_addr == 16'hF004) m_reload = (m_reload & 8'h0F) | (int'(cpu_data[3:0]) << 4);
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !rst) check("R7 model compare", irq_o, m_irq);
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_data  = d;
        cpu_wr    = 1'b1;
        cpu_cycle = 1'b1;
    endtask

    task automatic run_n(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_wr    = 1'b0;
            cpu_cycle = gap ? i[0] : 1'b1;
        end
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(2 * HALF * LIMIT_CYCLES);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1;
        @(posedge clk); #2;
        check("R1 irq low after reset", irq_o, 1'b0);
        run_n(300, 0);
        check("R1 idle after reset", irq_o, 1'b0);

        // Reload value from reset is 0x00: 256 steps to the first request
        wr(16'hF008, 8'h02);
        run_n(256 * 114 - 1, 0);
        check("R1 R7 cleared reload one cycle early", irq_o, 1'b0);
        run_n(1, 0);
        check("R1 R7 cleared reload wrap", irq_o, 1'b1);
        run_n(500, 0);
        check("R8 request held while counting", irq_o, 1'b1);

        // Wrong addresses and no strobe
        wr(16'hF00C, 8'h00);
        wr(16'hF009, 8'h02);
        wr(16'hE008, 8'h00);
        run_n(1, 0);
        cpu_addr = 16'hF008;
        cpu_data = 8'h00;
        run_n(3, 0);
        check("R9 stray writes ignored", irq_o, 1'b1);

        // Stop with acknowledge
        wr(16'hF008, 8'h00);
        run_n(1, 0);
        check("R5 ack on stop", irq_o, 1'b0);
        run_n(1000, 0);
        check("R4 stopped timer stays quiet", irq_o, 1'b0);

        // Reload 0xFE with junk in upper data bits
        wr(16'hF000, 8'h3E);
        wr(16'hF004, 8'hAF);
        wr(16'hF008, 8'h02);
        run_n(227, 0);
        check("R2 R3 R6 reload FE early", irq_o, 1'b0);
        run_n(1, 0);
        check("R2 R3 R7 reload FE wrap", irq_o, 1'b1);

        // Reload 0xFF, free-run bit set
        wr(16'hF000, 8'h0F);
        wr(16'hF008, 8'h03);
        run_n(1, 0);
        check("R5 ack on rearm", irq_o, 1'b0);
        run_n(112, 0);
        check("R7 reload FF early", irq_o, 1'b0);
        run_n(1, 0);
        check("R7 reload FF wrap", irq_o, 1'b1);

        // Gated CPU cycles: only half the clocks count
        wr(16'hF008, 8'h02);
        run_n(227, 1);
        check("R6 gated cycles early", irq_o, 1'b0);
        run_n(2, 1);
        check("R6 gated cycles wrap", irq_o, 1'b1);

        // Control write on the exact step cycle
        wr(16'hF008, 8'h02);
        run_n(113, 0);
        wr(16'hF008, 8'h02);
        run_n(113, 0);
        check("R10 write wins over step", irq_o, 1'b0);
        run_n(1, 0);
        check("R10 restart from write", irq_o, 1'b1);

        run_n(20, 0);
        finish_run();
    end

endmodule